// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt request lines and presents them to a processor as one interrupt output. Each request line passes through a two-flop synchronizer. The synchronized level is the pending state, so a pending bit is high exactly while its line is held high. Software never clears pending bits. To stop a request, software either removes its cause at the source or masks it.

An enable register selects which pending lines may raise the output. A small 32-bit register port gives access to this register and to the pending state. Each access is a single-cycle request made of a valid strobe, a write flag, a byte offset and write data. Read data and an access-error pulse come back on the following cycle. Two control offsets accept writes and discard them without error. Any other unsupported access is reported on the error pulse.

Top module: `lic_irq_ctl`

## Requirements
- R1: After reset, the pending register, the enable register, `irq_out`, `rsp_rdata` and `acc_err` are all zero.
- R2: Pending bit i equals the level of `irq_lines[i]` as seen through a two-flop synchronizer. A read at byte offset 0x0C returns the pending bits in the low positions.
- R3: The enable register sits at byte offset 0x04. It can be read and written, and each write replaces its whole content.
- R4: Offset 0x0C is read-only. A write there flags `acc_err` and changes no state.
- R5: Writes to byte offsets 0x00 and 0x14 raise no `acc_err` and change no state.
- R6: Reads at any offset other than 0x04 and 0x0C return zero and flag `acc_err`. Writes at any offset other than 0x00, 0x04 and 0x14 are dropped and flag `acc_err`. Offsets that are not multiples of 4 are unsupported.
- R7: `irq_out` is high when the bitwise AND of the enable register and the pending register is non-zero, and low otherwise.
- R8: Bits at or above `NUM_LINES` in the enable and pending registers read as zero and ignore writes.
- R9: `rsp_rdata` and `acc_err` take effect on the clock edge that samples the request. `acc_err` is a one-cycle pulse that is low in any cycle without a bad request.
- R10: `irq_out` reflects an enable write one clock edge after the write is sampled. It reflects a change on an input line three clock edges after the line changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt request lines |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| acc_err | output | 1 | One-cycle pulse for an unsupported access |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
An enable write and a change on a request line can land in the same cycle. Both then feed the single registered output together. The bench provokes this by changing the lines and writing the enable register in one request cycle, from a state where neither change alone would move the output. Once the three-edge line latency has run out, it judges `irq_out` against the AND of the new enable value and the new line levels. A second collision, a read of the pending offset while the lines change, is judged by requiring the returned value to match either the old or the new line levels.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [31:0] OFF_NOP_LO = 32'h00;
  localparam logic [31:0] OFF_ENABLE = 32'h04;
  localparam logic [31:0] OFF_LEVEL  = 32'h0C;
  localparam logic [31:0] OFF_NOP_HI = 32'h14;

  typedef struct packed {
    logic en_wr;
    logic en_rd;
    logic lvl_rd;
    logic bad;
  } dec_t;

  function automatic dec_t decode_access(input logic [31:0] off, input logic wr);
    dec_t d;
    d = '0;
    if (wr) begin
      d.en_wr = (off == OFF_ENABLE);
      d.bad   = !((off == OFF_ENABLE) || (off == OFF_NOP_LO) || (off == OFF_NOP_HI));
    end else begin
      d.en_rd  = (off == OFF_ENABLE);
      d.lvl_rd = (off == OFF_LEVEL);
      d.bad    = !((off == OFF_ENABLE) || (off == OFF_LEVEL));
    end
    return d;
  endfunction

endpackage

// File: rtl/lic_rst_sync.sv
module lic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [REG_W-1:0]     req_wdata,
  input  logic [NUM_LINES-1:0] level,
  output logic [NUM_LINES-1:0] enable_q,
  output logic [REG_W-1:0]     rsp_rdata,
  output logic                 acc_err
);
  dec_t                 dec;
  logic                 en_load;
  logic [NUM_LINES-1:0] enable_d;
  logic                 rd_load;
  logic [REG_W-1:0]     rdata_d;
  logic [REG_W-1:0]     rdata_q;
  logic                 err_d;
  logic                 err_q;

  always_comb begin
    dec      = decode_access(32'(req_addr), req_write);
    en_load  = req_valid && dec.en_wr;
    enable_d = req_wdata[NUM_LINES-1:0];
    rd_load  = req_valid && !req_write;
    rdata_d  = '0;
    if (dec.en_rd)  rdata_d = REG_W'(enable_q);
    if (dec.lvl_rd) rdata_d = REG_W'(level);
    err_d    = req_valid && dec.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enable_q <= '0;
    else if (en_load) enable_q <= enable_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_load) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign rsp_rdata = rdata_q;
  assign acc_err   = err_q;
endmodule

// File: rtl/lic_combine.sv
module lic_combine #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] enable,
  input  logic [NUM_LINES-1:0] level,
  output logic                 irq_out
);
  logic irq_d;
  logic irq_q;

  always_comb irq_d = |(enable & level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/lic_irq_ctl.sv
module lic_irq_ctl
  import lic_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  output logic                 acc_err,
  output logic                 irq_out
);
  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] level_q;
  logic [NUM_LINES-1:0] enable_q;

  lic_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lic_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (irq_lines),
    .dout  (level_q)
  );

  lic_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .level     (level_q),
    .enable_q  (enable_q),
    .rsp_rdata (rsp_rdata),
    .acc_err   (acc_err)
  );

  lic_combine #(.NUM_LINES(NUM_LINES)) comb_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .enable  (enable_q),
    .level   (level_q),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/lic_irq_ctl_chk.sv
module lic_irq_ctl_chk #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [31:0]          req_wdata,
  input logic [NUM_LINES-1:0] enable_q,
  input logic [NUM_LINES-1:0] level_q,
  input logic                 acc_err,
  input logic                 irq_out
);
  logic [31:0] off;
  logic        nop_wr;
  logic        bad_acc;

  always_comb begin
    off     = 32'(req_addr);
    nop_wr  = req_valid && req_write && (off == 32'h00 || off == 32'h14);
    bad_acc = req_valid && (req_write ? !(off == 32'h00 || off == 32'h04 || off == 32'h14)
                                      : !(off == 32'h04 || off == 32'h0C));
  end

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(enable_q & level_q)) |=> irq_out);

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(enable_q & level_q)) |=> !irq_out);

  assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && off == 32'h04) |=> (enable_q == $past(req_wdata[NUM_LINES-1:0])));

  assert_nop_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nop_wr |=> ($stable(enable_q) && !acc_err));

  assert_bad_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> acc_err);

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_acc |=> !acc_err);
endmodule

bind lic_irq_ctl lic_irq_ctl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .enable_q  (enable_q),
  .level_q   (level_q),
  .acc_err   (acc_err),
  .irq_out   (irq_out)
);

// File: tb/lic_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module lic_irq_ctl_tb_top;
  localparam int unsigned NL = 8;
  localparam int unsigned AW = 8;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] irq_lines;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic [31:0]   rsp_rdata;
  logic          acc_err;
  logic          irq_out;

  int checks;
  int errors;
  bit finished;

  lic_irq_ctl #(.NUM_LINES(NL), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .acc_err   (acc_err),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Request presented at a negedge, sampled at the next posedge; response read at the following negedge.
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    req_wdata = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] pats [8];
    pats[0] = 8'h00; pats[1] = 8'h01; pats[2] = 8'h80; pats[3] = 8'h5A;
    pats[4] = 8'hA5; pats[5] = 8'hFF; pats[6] = 8'h10; pats[7] = 8'h3C;

    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; irq_lines = '0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    settle(4);
    // R1: reset state
    chk("R1 irq_out", 32'(irq_out), 32'd0);
    chk("R1 rsp_rdata", rsp_rdata, 32'd0);
    chk("R1 acc_err", 32'(acc_err), 32'd0);
    rst_n = 1'b1;
    settle(3);
    access(1'b0, 8'h04, '0); chk("R1 enable", rsp_rdata, 32'd0);
    access(1'b0, 8'h0C, '0); chk("R1 pending", rsp_rdata, 32'd0);

    // R2/R7/R10: sweep all enable values against a set of line patterns
    for (int p = 0; p < 8; p++) begin
      irq_lines = pats[p];
      settle(3);
      access(1'b0, 8'h0C, '0);
      chk("R2 pending readback", rsp_rdata, 32'(pats[p]));
      for (int m = 0; m < 256; m++) begin
        access(1'b1, 8'h04, 32'(m));
        chk("R5 mask write no error", 32'(acc_err), 32'd0);
        settle(1);
        chk("R7 irq_out combine", 32'(irq_out), 32'(((NL'(m)) & pats[p]) != 0));
      end
    end

    // R3: readback and full replacement
    access(1'b1, 8'h04, 32'h0000_00C3);
    access(1'b0, 8'h04, '0); chk("R3 enable readback", rsp_rdata, 32'h0000_00C3);
    access(1'b1, 8'h04, 32'h0000_0014);
    access(1'b0, 8'h04, '0); chk("R3 enable replaced", rsp_rdata, 32'h0000_0014);

    // R8: upper bits dropped
    access(1'b1, 8'h04, 32'hFFFF_FFFF);
    access(1'b0, 8'h04, '0); chk("R8 enable upper bits", rsp_rdata, 32'h0000_00FF);
    irq_lines = 8'hFF; settle(3);
    access(1'b0, 8'h0C, '0); chk("R8 pending upper bits", rsp_rdata, 32'h0000_00FF);

    // R5: no-op writes
    access(1'b1, 8'h00, 32'h0); chk("R5 nop lo err", 32'(acc_err), 32'd0);
    access(1'b1, 8'h14, 32'h0); chk("R5 nop hi err", 32'(acc_err), 32'd0);
    settle(1); chk("R5 irq unchanged", 32'(irq_out), 32'd1);
    access(1'b0, 8'h04, '0); chk("R5 enable unchanged", rsp_rdata, 32'h0000_00FF);

    // R4: write to pending offset
    access(1'b1, 8'h0C, 32'h0); chk("R4 write ro err", 32'(acc_err), 32'd1);
    access(1'b0, 8'h0C, '0); chk("R4 pending unchanged", rsp_rdata, 32'h0000_00FF);
    chk("R9 err pulse ends", 32'(acc_err), 32'd0);

    // R6: unsupported reads and writes, including misaligned
    for (int a = 0; a < 32; a++) begin
      logic ok_rd, ok_wr;
      ok_rd = (a == 4) || (a == 12);
      ok_wr = (a == 0) || (a == 4) || (a == 20);
      access(1'b0, AW'(a), '0);
      chk("R6 read err", 32'(acc_err), 32'(!ok_rd));
      if (!ok_rd) chk("R6 read zero", rsp_rdata, 32'd0);
      if (!ok_wr) begin
        access(1'b1, AW'(a), 32'h0);
        chk("R6 write err", 32'(acc_err), 32'd1);
        settle(1);
        chk("R9 err one cycle", 32'(acc_err), 32'd0);
      end
    end
    access(1'b0, 8'h04, '0); chk("R6 enable intact", rsp_rdata, 32'h0000_00FF);

    // R10: line latency is three edges
    access(1'b1, 8'h04, 32'h01);
    irq_lines = 8'h00; settle(4);
    chk("R10 idle low", 32'(irq_out), 32'd0);
    irq_lines = 8'h01;
    settle(2); chk("R10 not yet", 32'(irq_out), 32'd0);
    settle(1); chk("R10 after three edges", 32'(irq_out), 32'd1);
    // R2: line drop clears pending, no software clear
    irq_lines = 8'h00; settle(3);
    chk("R2 level drop", 32'(irq_out), 32'd0);

    // Collision: enable write and line change in the same cycle
    irq_lines = 8'h40;
    access(1'b1, 8'h04, 32'h40);
    settle(3);
    chk("R7 coincident write and line", 32'(irq_out), 32'd1);
    // Collision: pending read while lines change
    irq_lines = 8'h0F;
    access(1'b0, 8'h0C, '0);
    checks++;
    if (!(rsp_rdata == 32'h40 || rsp_rdata == 32'h0F)) begin
      errors++;
      $display("FAIL R2 read during change actual=%h expected=%h", rsp_rdata, 32'h40);
    end

    // R1: reset again mid-run
    rst_n = 1'b0; settle(2);
    chk("R1 irq after reset", 32'(irq_out), 32'd0);
    rst_n = 1'b1; settle(3);
    access(1'b0, 8'h04, '0); chk("R1 enable after reset", rsp_rdata, 32'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule